// File: doc/BRIEF.md
# ADC Trigger Rate Reducer with Counting-Phase Filter

This block sits between an already-selected timer event stream and an ADC trigger input. It lowers the trigger rate. A prescale field of N lets one output pulse through for every N+1 qualifying events. The events it absorbs are simply dropped.

Before any counting, each event passes a phase filter. When the source timer runs in up/down (center-aligned) counting, a 2-bit selector decides which events qualify: those from the up-counting phase, those from the down-counting phase, or both. The filter treats reset, period roll-over and compare events the same way, because it only sees the event pulse and the direction flag. When the timer counts in one direction only, every event qualifies.

The reduced trigger is a registered single-cycle pulse. It appears one clock after the qualifying event.

Top module: `adc_trig_postscale`

## Requirements
- R1: While `rst` is high and on the first clock after it, `trig_o` is 0, and the divide counter is cleared and re-armed.
- R2: With `psc_i` held at N, after the first output the block emits one `trig_o` pulse for every N+1 qualifying events.
- R3: With `psc_i` = 0, every qualifying event produces a `trig_o` pulse.
- R4: `trig_o` goes high in the clock cycle after the cycle in which the qualifying event was sampled, for exactly one cycle per pulse. It is 0 in any cycle whose preceding sampled `evt_i` was 0.
- R5: With `center_i` = 1 and `phase_sel_i` = 2'b00, events qualify in both directions.
- R6: With `center_i` = 1 and `phase_sel_i` = 2'b01, only events with `cnt_down_i` = 1 (counting down) qualify.
- R7: With `center_i` = 1 and `phase_sel_i` = 2'b10, only events with `cnt_down_i` = 0 (counting up) qualify.
- R8: `phase_sel_i` = 2'b11 behaves exactly like 2'b00.
- R9: With `center_i` = 0, every event qualifies, whatever the values of `phase_sel_i` and `cnt_down_i`.
- R10: The first qualifying event after reset, or in or after a cycle where `psc_i` differs from its previous value, produces a pulse. Counting then restarts from zero.
- R11: An event rejected by the phase filter does not advance the divide counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Selected trigger event, one cycle per event |
| cnt_down_i | input | 1 | Source timer direction: 1 = counting down, 0 = counting up |
| center_i | input | 1 | Source timer is in up/down counting mode |
| phase_sel_i | input | 2 | Phase filter: 00 both, 01 down only, 10 up only, 11 as 00 |
| psc_i | input | PSC_W | Prescale N: one output per N+1 qualifying events |
| trig_o | output | 1 | Reduced ADC trigger pulse (registered) |

## Verification
The assertions assume that `evt_i`, `cnt_down_i`, `center_i`, `phase_sel_i` and `psc_i` are synchronous to `clk` and sampled once per edge. They make no assumption on how often events arrive or on when the configuration changes. Consecutive-cycle events and prescale changes that land on an event cycle are both legal. The bench drives every input at the falling edge, so each value is settled a half period before it is sampled. The random phase deliberately changes the prescale rarely, so long stretches with a stable prescale exercise full divide cycles between the restarts.

// File: rtl/trig_ps_pkg.sv
package trig_ps_pkg;
  typedef enum logic [1:0] {
    PH_BOTH = 2'b00,
    PH_DOWN = 2'b01,
    PH_UP   = 2'b10,
    PH_ALT  = 2'b11
  } phase_sel_e;

  function automatic logic phase_pass(input phase_sel_e sel, input logic down);
    case (sel)
      PH_DOWN: phase_pass = down;
      PH_UP:   phase_pass = !down;
      default: phase_pass = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/trig_phase_qual.sv
module trig_phase_qual
  import trig_ps_pkg::*;
(
  input  logic       evt_i,
  input  logic       cnt_down_i,
  input  logic       center_i,
  input  logic [1:0] phase_sel_i,
  output logic       qual_o
);
  phase_sel_e sel;

  always_comb begin
    sel    = phase_sel_e'(phase_sel_i);
    qual_o = evt_i && (!center_i || phase_pass(sel, cnt_down_i));
  end
endmodule

// File: rtl/trig_div_count.sv
module trig_div_count #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             pulse_o,
  output logic [PSC_W-1:0] cnt_o,
  output logic [PSC_W-1:0] psc_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             arm_q;
  logic             arm_eff;
  logic             hit;

  always_comb begin
    arm_eff = arm_q || (psc_i != psc_q);
    hit     = qual_i && (arm_eff || (cnt_q == psc_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      arm_q   <= 1'b1;
      psc_q   <= psc_i;
      pulse_o <= 1'b0;
    end else begin
      psc_q   <= psc_i;
      pulse_o <= hit;
      if (hit) begin
        cnt_q <= '0;
        arm_q <= 1'b0;
      end else if (arm_eff) begin
        cnt_q <= '0;
        arm_q <= 1'b1;
      end else if (qual_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign psc_o = psc_q;
endmodule

// File: rtl/adc_trig_postscale.sv
module adc_trig_postscale #(
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             cnt_down_i,
  input  logic             center_i,
  input  logic [1:0]       phase_sel_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             trig_o
);
  logic             qual;
  logic [PSC_W-1:0] cnt_w;
  logic [PSC_W-1:0] psc_w;

  trig_phase_qual u_qual (
    .evt_i       (evt_i),
    .cnt_down_i  (cnt_down_i),
    .center_i    (center_i),
    .phase_sel_i (phase_sel_i),
    .qual_o      (qual)
  );

  trig_div_count #(.PSC_W(PSC_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .qual_i  (qual),
    .psc_i   (psc_i),
    .pulse_o (trig_o),
    .cnt_o   (cnt_w),
    .psc_o   (psc_w)
  );
endmodule

// File: rtl/adc_trig_postscale_chk.sv
module adc_trig_postscale_chk #(
  parameter int PSC_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_i,
  input logic             cnt_down_i,
  input logic             center_i,
  input logic [1:0]       phase_sel_i,
  input logic [PSC_W-1:0] psc_i,
  input logic             trig_o,
  input logic [PSC_W-1:0] cnt_w,
  input logic [PSC_W-1:0] psc_w
);
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !trig_o);

  p_no_evt_no_trig_r4: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> !trig_o);

  p_down_only_r6: assert property (@(posedge clk) disable iff (rst)
    (center_i && phase_sel_i == 2'b01 && !cnt_down_i) |=> !trig_o);

  p_up_only_r7: assert property (@(posedge clk) disable iff (rst)
    (center_i && phase_sel_i == 2'b10 && cnt_down_i) |=> !trig_o);

  p_pass_all_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_i && psc_i == '0 && (!center_i || phase_sel_i[0] == phase_sel_i[1]))
      |=> trig_o);

  p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_i && !center_i && psc_i != psc_w) |=> trig_o);

  p_first_after_change_r10: assert property (@(posedge clk) disable iff (rst)
    (evt_i && (!center_i || phase_sel_i == 2'b00) && psc_i != psc_w) |=> trig_o);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_w <= psc_w);
endmodule

bind adc_trig_postscale adc_trig_postscale_chk #(.PSC_W(PSC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt_i       (evt_i),
  .cnt_down_i  (cnt_down_i),
  .center_i    (center_i),
  .phase_sel_i (phase_sel_i),
  .psc_i       (psc_i),
  .trig_o      (trig_o),
  .cnt_w       (cnt_w),
  .psc_w       (psc_w)
);

// File: tb/adc_trig_postscale_tb.sv
module adc_trig_postscale_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PSC_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             evt_i = 1'b0;
  logic             cnt_down_i = 1'b0;
  logic             center_i = 1'b0;
  logic [1:0]       phase_sel_i = 2'b00;
  logic [PSC_W-1:0] psc_i = '0;
  logic             trig_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [PSC_W-1:0] m_cnt;
  logic [PSC_W-1:0] m_psc;
  bit               m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_postscale #(.PSC_W(PSC_W)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .cnt_down_i(cnt_down_i),
    .center_i(center_i), .phase_sel_i(phase_sel_i), .psc_i(psc_i), .trig_o(trig_o)
  );

  function automatic bit qualifies(bit e, bit d, bit c, logic [1:0] ph);
    if (!e) return 0;
    if (!c) return 1;
    if (ph == 2'b01) return d;
    if (ph == 2'b10) return !d;
    return 1;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit e, input bit d, input bit c, input logic [1:0] ph,
                      input logic [PSC_W-1:0] p, input string req);
    bit q, exp;
    @(negedge clk);
    evt_i = e; cnt_down_i = d; center_i = c; phase_sel_i = ph; psc_i = p;
    q = qualifies(e, d, c, ph);
    if (p != m_psc) begin m_arm = 1; m_cnt = '0; end
    m_psc = p;
    exp = q && (m_arm || m_cnt == p);
    if (exp) begin m_cnt = '0; m_arm = 0; end
    else if (q) m_cnt = m_cnt + 1'b1;
    @(posedge clk); #1;
    check(trig_o, exp, req);
  endtask

  task automatic do_reset(input logic [PSC_W-1:0] p);
    @(negedge clk);
    rst = 1; evt_i = 1; psc_i = p;
    repeat (3) begin
      @(posedge clk); #1;
      check(trig_o, 1'b0, "R1");
    end
    @(negedge clk);
    rst = 0; evt_i = 0;
    m_cnt = '0; m_arm = 1; m_psc = p;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(5'd3);
    step(0,0,0,2'b00,5'd3,"R1");
    // R10: first event after reset fires
    step(1,0,0,2'b00,5'd3,"R10");
    step(0,0,0,2'b00,5'd3,"R4");
    // R2: N=3 -> three absorbed, fourth fires
    for (int i = 0; i < 3; i++) step(1,0,0,2'b00,5'd3,"R2");
    step(1,0,0,2'b00,5'd3,"R2");
    step(1,0,0,2'b00,5'd3,"R2");
    // R10: change prescale mid-count, next event fires
    step(1,0,0,2'b00,5'd7,"R10");
    step(1,0,0,2'b00,5'd7,"R10");
    // R3: prescale 0 passes every event
    for (int i = 0; i < 4; i++) step(1,0,0,2'b00,5'd0,"R3");
    step(0,0,0,2'b00,5'd0,"R4");
    // R5 both, R6 down, R7 up, R8 reserved, all with psc 0
    step(1,0,1,2'b00,5'd0,"R5"); step(1,1,1,2'b00,5'd0,"R5");
    step(1,1,1,2'b01,5'd0,"R6"); step(1,0,1,2'b01,5'd0,"R6");
    step(1,0,1,2'b10,5'd0,"R7"); step(1,1,1,2'b10,5'd0,"R7");
    step(1,0,1,2'b11,5'd0,"R8"); step(1,1,1,2'b11,5'd0,"R8");
    // R9: not center-aligned -> filter ignored
    step(1,0,0,2'b01,5'd0,"R9"); step(1,1,0,2'b10,5'd0,"R9");
    // R11: rejected events do not advance count (psc 2, up-only)
    step(1,0,1,2'b10,5'd2,"R11");
    for (int i = 0; i < 5; i++) step(1,1,1,2'b10,5'd2,"R11");
    step(1,0,1,2'b10,5'd2,"R11");
    step(1,1,1,2'b10,5'd2,"R11");
    step(1,0,1,2'b10,5'd2,"R11");
    step(1,0,1,2'b10,5'd2,"R11");
    // reset restart R1 / R10
    do_reset(5'd4);
    step(1,1,1,2'b01,5'd4,"R10");
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [PSC_W-1:0] p;
      p = (($urandom % 64) == 0) ? PSC_W'($urandom % 8) : m_psc;
      step(($urandom % 3) != 0, $urandom % 2, $urandom % 2,
           2'($urandom % 4), p, "R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule